// File: doc/BRIEF.md
# Bridge Downstream Memory Window Decoder

This block keeps the two bound registers of a non-prefetchable memory window on a host-to-PCI Express bridge. It uses them to decide, for every 32-bit processor memory address, whether the access belongs downstream. Configuration software programs the lower and upper bounds through a small 16-bit register port. The address check is combinational and produces a single hit flag.

The window has a granularity of one megabyte. Only address bits A[31:20] of each bound can be programmed. The lower bound's low twenty address bits are taken as all zeros and the upper bound's as all ones, so the window always covers whole 1 MB blocks. Both bounds are inclusive. A separate enable input gates the hit flag, so that the all-zero reset contents do not claim the first megabyte. No check is made for overlap with other windows or with main memory: whatever is programmed is decoded as written.

Top module: `mem_window_decoder`

## Requirements
- R1: After reset, both bound registers read 0000h, read data is 0000h and hit is low.
- R2: A write to offset 20h (lower bound) stores write-data bits 15:4, which give A[31:20] of the lowest address in the window, and a later read of 20h returns them.
- R3: A write to offset 22h (upper bound) stores write-data bits 15:4, which give A[31:20] of the highest address in the window, and a later read of 22h returns them.
- R4: Bits 3:0 of both bound registers always read as zero, whatever value is written to them.
- R5: A read of any offset other than 20h or 22h returns 0000h, and a write to such an offset changes neither bound nor the decode result.
- R6: With enable high, hit is high exactly when {lower,00000h} <= address <= {upper,FFFFFh}, with both ends inclusive.
- R7: When the programmed lower bound is greater than the upper bound, no address hits.
- R8: When the enable input is low, hit is low for every address.
- R9: hit follows the address and enable combinationally, and a register write changes the decode only from the clock edge that captures the write.
- R10: Read data is registered. cfg_rdata shows the register selected by cfg_off in the previous cycle.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_off | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe for the addressed register |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Registered read data of the offset presented in the previous cycle |
| win_en | input | 1 | Window enable, gates the hit output |
| addr | input | 32 | Processor memory address under test |
| hit | output | 1 | Address falls within the enabled window |

## Verification
The hardest situation to reach is the cycle in which a bound write is on the port but not yet captured. In that cycle the decode must still reflect the old bound. The bench holds a probe address just outside the old upper bound, drives the write half a cycle before the edge and samples hit both before and after that edge. It also walks the four addresses on each side of the inclusive boundaries, including a window exactly one megabyte wide, and programs an inverted window whose bounds straddle the probe addresses.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  // Default geometry of the window registers
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned GRAN_W_DEF = 20;
  localparam int unsigned REG_W_DEF  = 16;
  localparam int unsigned OFF_W_DEF  = 8;

  // Mask of the writable upper field of a bound register
  function automatic logic [REG_W_DEF-1:0] field_mask(input int unsigned reg_w,
                                                      input int unsigned field_w);
    logic [REG_W_DEF-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W_DEF; i++) begin
      if (i < reg_w && i >= (reg_w - field_w)) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/mwd_bound_reg.sv
module mwd_bound_reg #(
  parameter int unsigned REG_W   = mwd_pkg::REG_W_DEF,
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned OFF_W   = mwd_pkg::OFF_W_DEF,
  parameter logic [OFF_W-1:0] MY_OFF = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OFF_W-1:0]   cfg_off,
  input  logic               cfg_we,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   rd_val,
  output logic [FIELD_W-1:0] field
);
  localparam int unsigned LOW_W = REG_W - FIELD_W;
  localparam logic [REG_W-1:0] RW_MASK = {{FIELD_W{1'b1}}, {LOW_W{1'b0}}};

  logic [REG_W-1:0] reg_q;
  logic             sel;

  assign sel = (cfg_off == MY_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= '0;
    end else if (cfg_we && sel) begin
      reg_q <= cfg_wdata & RW_MASK;
    end
  end

  assign rd_val = sel ? reg_q : '0;
  assign field  = reg_q[REG_W-1 -: FIELD_W];

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (reg_q == '0));
  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sel) |=> (field == $past(cfg_wdata[REG_W-1 -: FIELD_W])));
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && sel) |=> $stable(reg_q));
  // R4
  low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_q[LOW_W-1:0] == '0);
endmodule

// File: rtl/mwd_range_cmp.sv
module mwd_range_cmp #(
  parameter int unsigned ADDR_W = mwd_pkg::ADDR_W_DEF,
  parameter int unsigned GRAN_W = mwd_pkg::GRAN_W_DEF,
  localparam int unsigned FIELD_W = ADDR_W - GRAN_W
) (
  input  logic               en,
  input  logic [FIELD_W-1:0] lo_field,
  input  logic [FIELD_W-1:0] hi_field,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  logic [ADDR_W-1:0] lo_addr;
  logic [ADDR_W-1:0] hi_addr;

  assign lo_addr = {lo_field, {GRAN_W{1'b0}}};
  assign hi_addr = {hi_field, {GRAN_W{1'b1}}};
  assign hit     = en && (addr >= lo_addr) && (addr <= hi_addr);
endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder #(
  parameter int unsigned ADDR_W = mwd_pkg::ADDR_W_DEF,
  parameter int unsigned GRAN_W = mwd_pkg::GRAN_W_DEF,
  parameter int unsigned REG_W  = mwd_pkg::REG_W_DEF,
  parameter int unsigned OFF_W  = mwd_pkg::OFF_W_DEF,
  parameter logic [OFF_W-1:0] LO_OFF = 8'h20,
  parameter logic [OFF_W-1:0] HI_OFF = 8'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned FIELD_W = ADDR_W - GRAN_W;
  localparam int unsigned N_REG   = 2;
  localparam logic [N_REG*OFF_W-1:0] OFFS = {HI_OFF, LO_OFF};

  logic [REG_W-1:0]   rd_vals [N_REG];
  logic [FIELD_W-1:0] fields  [N_REG];
  logic [REG_W-1:0]   rd_mux;
  logic [REG_W-1:0]   rdata_q;

  for (genvar g = 0; g < N_REG; g++) begin : g_bound
    mwd_bound_reg #(
      .REG_W(REG_W), .FIELD_W(FIELD_W), .OFF_W(OFF_W),
      .MY_OFF(OFFS[g*OFF_W +: OFF_W])
    ) u_reg (
      .clk(clk), .rst(rst), .cfg_off(cfg_off), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .rd_val(rd_vals[g]), .field(fields[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_REG; i++) rd_mux = rd_mux | rd_vals[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end
  assign cfg_rdata = rdata_q;

  mwd_range_cmp #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_cmp (
    .en(win_en), .lo_field(fields[0]), .hi_field(fields[1]),
    .addr(addr), .hit(hit)
  );

  // R8
  en_gate_chk: assert property (@(posedge clk) disable iff (rst) !win_en |-> !hit);
  // R7
  inverted_chk: assert property (@(posedge clk) disable iff (rst)
    (fields[0] > fields[1]) |-> !hit);
  // R5
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_off != LO_OFF) && (cfg_off != HI_OFF)) |=> (cfg_rdata == '0));
  // R1
  rst_rdata_chk: assert property (@(posedge clk) rst |=> (cfg_rdata == '0));
endmodule

// File: tb/sim_mem_window_decoder.sv
`timescale 1ns/1ps
module sim_mem_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_off = 8'h00;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic        win_en = 1'b0;
  logic [31:0] addr = 32'h0;
  logic        hit;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_window_decoder u0 (
    .clk(clk), .rst(rst), .cfg_off(cfg_off), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .win_en(win_en),
    .addr(addr), .hit(hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [15:0] d);
    @(negedge clk);
    cfg_off = off; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [15:0] exp);
    @(negedge clk);
    cfg_off = off;
    @(negedge clk);
    check(req, {16'h0, cfg_rdata}, {16'h0, exp});
  endtask

  task automatic hit_chk(input string req, input logic [31:0] a, input logic exp);
    addr = a;
    #1;
    check(req, {31'h0, hit}, {31'h0, exp});
  endtask

  task automatic t_reset();
    check("R1 rdata", {16'h0, cfg_rdata}, 32'h0);
    rd_chk("R1 lower", 8'h20, 16'h0000);
    rd_chk("R1 upper", 8'h22, 16'h0000);
    hit_chk("R1 hit", 32'h0, 1'b0);
  endtask

  task automatic t_enable();
    win_en = 1'b1;
    hit_chk("R6 reset window", 32'h0001_2345, 1'b1);
    win_en = 1'b0;
    hit_chk("R8 disabled", 32'h0001_2345, 1'b0);
    win_en = 1'b1;
  endtask

  task automatic t_regs();
    wr(8'h20, 16'hABCF);
    rd_chk("R2 R4 lower", 8'h20, 16'hABC0);
    wr(8'h22, 16'hFFFF);
    rd_chk("R3 R4 upper", 8'h22, 16'hFFF0);
  endtask

  task automatic t_unmapped();
    wr(8'h24, 16'h1234);
    wr(8'h00, 16'h0010);
    rd_chk("R5 rd 24h", 8'h24, 16'h0000);
    rd_chk("R5 rd 00h", 8'h00, 16'h0000);
    rd_chk("R5 lower kept", 8'h20, 16'hABC0);
    rd_chk("R5 upper kept", 8'h22, 16'hFFF0);
    hit_chk("R5 decode kept", 32'hABC0_0000, 1'b1);
    hit_chk("R5 decode kept low", 32'hABBF_FFFF, 1'b0);
  endtask

  task automatic t_range();
    wr(8'h20, 16'h1000);
    wr(8'h22, 16'h1FF0);
    hit_chk("R6 base", 32'h1000_0000, 1'b1);
    hit_chk("R6 below", 32'h0FFF_FFFF, 1'b0);
    hit_chk("R6 top", 32'h1FFF_FFFF, 1'b1);
    hit_chk("R6 above", 32'h2000_0000, 1'b0);
    wr(8'h20, 16'h3450);
    wr(8'h22, 16'h3450);
    hit_chk("R6 1MB low", 32'h3450_0000, 1'b1);
    hit_chk("R6 1MB high", 32'h345F_FFFF, 1'b1);
    hit_chk("R6 1MB next", 32'h3460_0000, 1'b0);
    hit_chk("R6 1MB prev", 32'h344F_FFFF, 1'b0);
  endtask

  task automatic t_inverted();
    wr(8'h20, 16'h3000);
    wr(8'h22, 16'h2000);
    hit_chk("R7 between", 32'h2500_0000, 1'b0);
    hit_chk("R7 at lower", 32'h3000_0000, 1'b0);
    hit_chk("R7 at upper", 32'h2000_0000, 1'b0);
  endtask

  task automatic t_timing();
    wr(8'h20, 16'h0000);
    wr(8'h22, 16'h0000);
    hit_chk("R9 before", 32'h0015_0000, 1'b0);
    @(negedge clk);
    cfg_off = 8'h22; cfg_we = 1'b1; cfg_wdata = 16'h0010;
    #1;
    check("R9 pending write", {31'h0, hit}, 32'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R9 after edge", {31'h0, hit}, 32'h1);
    win_en = 1'b0;
    #1;
    check("R9 R8 comb enable", {31'h0, hit}, 32'h0);
    win_en = 1'b1;
  endtask

  task automatic t_latency();
    wr(8'h20, 16'h5550);
    rd_chk("R10 upper", 8'h22, 16'h0010);
    @(negedge clk);
    cfg_off = 8'h20;
    #1;
    check("R10 old data", {16'h0, cfg_rdata}, 32'h0010);
    @(negedge clk);
    check("R10 new data", {16'h0, cfg_rdata}, 32'h5550);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_regs();
    t_unmapped();
    t_range();
    t_inverted();
    t_timing();
    t_latency();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule